// File: doc/BRIEF.md
# Integer ALU with status flags

This block is the 32-bit integer arithmetic and logic unit of a DSP datapath. Each cycle it takes two operands, a 4-bit operation code, an overflow-mode (saturation) enable and the current status word. It returns the result combinationally. The updated status word is captured in a register when the update enable is high.

The arithmetic operations are add, add with carry, subtract, subtract with borrow, reverse subtract, negate, negate with borrow and absolute value. The logic operations are AND, AND with inverted second operand, OR, XOR and NOT. There are also rotates left and right through the carry bit, and a conditional-subtract step used to build long division one quotient bit at a time.

Each arithmetic operation rewrites the carry, overflow, zero and negative bits and adds any overflow into a sticky latched-overflow bit. When overflow mode is on, a result that overflows is clamped to the signed extreme.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 returns a+b and code 1 returns a+b+C, where C is bit 0 of `st_in`. The new carry is the unsigned carry out of that sum.
- R2: These codes return the following differences, and the new carry is set when the unsigned subtraction needs a borrow:
  - code 2 returns a-b;
  - code 3 returns a-b-C;
  - code 4 returns b-a;
  - code 5 returns 0-b;
  - code 6 returns 0-b-C.
- R3: For codes 0 to 7, the overflow bit (status bit 1) is set exactly when the ideal signed result does not fit in 32 bits.
- R4: When `sat_mode` is 1 and an operation with codes 0 to 7 overflows, the result is clamped by the sign of the first operand of the computation. That operand is a for codes 0 to 3, b for code 4, and zero for codes 5 to 7. A non-negative first operand gives 0x7FFFFFFF and a negative one gives 0x80000000. When `sat_mode` is 0, the wrapped value is returned.
- R5: The latched-overflow bit (status bit 5) is set whenever overflow is flagged. No operation clears it, and an incoming 1 is kept.
- R6: Code 7 returns the absolute value of b and always clears the carry. The absolute value of 0x80000000 overflows.
- R7: Codes 8 to 12 return the following values, and each clears carry and overflow:
  - code 8 returns a AND b;
  - code 9 returns a AND NOT b;
  - code 10 returns a OR b;
  - code 11 returns a XOR b;
  - code 12 returns NOT b.
- R8: Code 13 shifts a left, with C entering bit 0 and bit 31 leaving into the carry. Code 14 shifts a right, with C entering bit 31 and bit 0 leaving into the carry. Both clear overflow.
- R9: Code 15 (divide step) returns ((a-b)<<1)|1 when bit 31 of a-b is 0, and a<<1 otherwise. It leaves the whole status word equal to `st_in`.
- R10: For codes 0 to 14, the zero bit (bit 2) is set when the final, post-clamp result is 0. The negative bit (bit 3) copies result bit 31.
- R11: Status bits other than 0, 1, 2, 3 and 5 are copied from `st_in` unchanged. These include the underflow bit 4.
- R12: `st_q` is cleared by reset. It loads the new status only in cycles where `upd_en` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_en | input | 1 | Capture the new status at the clock edge |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand (destination value) |
| opnd_b | input | 32 | Second operand (source value) |
| sat_mode | input | 1 | Clamp overflowing results |
| st_in | input | 8 | Current status word |
| res | output | 32 | Combinational result |
| st_q | output | 8 | Registered updated status word |

## Verification
The hardest cases to reach are the exact overflow boundaries of the carry-using and negating operations. Examples are 0x7FFFFFFF plus zero with the carry set, and negate-with-borrow of zero. Another is the interplay of clamping with a reverse subtract, where the clamp direction follows b rather than a.

Uniform random operands almost never land there. The stimulus therefore draws each operand about half the time from a small set of extreme values (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF), randomizes the incoming carry and latched bits, and adds directed cases for each boundary.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDC  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBB  = 4'd3,
      OP_RSUB  = 4'd4,
      OP_NEG   = 4'd5,
      OP_NEGB  = 4'd6,
      OP_ABS   = 4'd7,
      OP_AND   = 4'd8,
      OP_ANDN  = 4'd9,
      OP_OR    = 4'd10,
      OP_XOR   = 4'd11,
      OP_NOT   = 4'd12,
      OP_ROLC  = 4'd13,
      OP_RORC  = 4'd14,
      OP_DSTEP = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      FL_ARITH,
      FL_LOGIC,
      FL_ROT,
      FL_KEEP
   } flag_cls_e;

   localparam int ST_C  = 0;
   localparam int ST_V  = 1;
   localparam int ST_Z  = 2;
   localparam int ST_N  = 3;
   localparam int ST_UF = 4;
   localparam int ST_LV = 5;
   localparam int ST_MIN_W = 6;

endpackage

// File: rtl/int_alu_addsub.sv
// Shared adder: x + y + cin, or x - y - bin. The carry output is the borrow
// when subtracting.
module int_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         cout,
   output logic         ovf
);
   logic [W:0]   sum;
   logic [W-1:0] yy;
   logic         ci;

   always_comb begin
      yy   = sub ? ~y : y;
      ci   = sub ? ~cin : cin;
      sum  = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, ci};
      r    = sum[W-1:0];
      cout = sub ? ~sum[W] : sum[W];
      ovf  = ~(x[W-1] ^ yy[W-1]) & (x[W-1] ^ sum[W-1]);
   end
endmodule

// File: rtl/int_alu_logic.sv
// Bitwise operations and the rotates through carry.
module int_alu_logic #(
   parameter int W = 32
) (
   input  int_alu_pkg::alu_op_e op,
   input  logic [W-1:0]         a,
   input  logic [W-1:0]         b,
   input  logic                 cin,
   output logic [W-1:0]         r,
   output logic                 cout
);
   import int_alu_pkg::*;

   always_comb begin
      r    = '0;
      cout = 1'b0;
      case (op)
         OP_AND:  r = a & b;
         OP_ANDN: r = a & ~b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_NOT:  r = ~b;
         OP_ROLC: begin
            r    = {a[W-2:0], cin};
            cout = a[W-1];
         end
         OP_RORC: begin
            r    = {cin, a[W-1:1]};
            cout = a[0];
         end
         default: r = '0;
      endcase
   end
endmodule

// File: rtl/int_alu_status.sv
// Clears the flags an operation owns, merges in the new ones, and registers
// the status word.
module int_alu_status #(
   parameter int W  = 32,
   parameter int SW = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  int_alu_pkg::flag_cls_e cls,
   input  logic                   c_new,
   input  logic                   v_new,
   input  logic [W-1:0]           res,
   input  logic [SW-1:0]          st_in,
   output logic [SW-1:0]          st_q
);
   import int_alu_pkg::*;

   logic [SW-1:0] nxt;
   logic          is_zero;

   always_comb begin
      is_zero = (res == '0);
      nxt     = st_in;
      if (cls != FL_KEEP) begin
         nxt[ST_C] = 1'b0;
         nxt[ST_V] = 1'b0;
         nxt[ST_Z] = is_zero;
         nxt[ST_N] = res[W-1];
      end
      case (cls)
         FL_ARITH: begin
            nxt[ST_C]  = c_new;
            nxt[ST_V]  = v_new;
            nxt[ST_LV] = st_in[ST_LV] | v_new;
         end
         FL_ROT:  nxt[ST_C] = c_new;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q <= '0;
      else if (en) st_q <= nxt;
   end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int W       = 32,
   parameter int SW      = 8,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_en,
   input  logic [3:0]    op_code,
   input  logic [W-1:0]  opnd_a,
   input  logic [W-1:0]  opnd_b,
   input  logic          sat_mode,
   input  logic [SW-1:0] st_in,
   output logic [W-1:0]  res,
   output logic [SW-1:0] st_q
);
   import int_alu_pkg::*;

   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   if (W < 2) begin : g_bad_w
      $error("int_alu: W must be at least 2");
   end
   if (SW < ST_MIN_W) begin : g_bad_sw
      $error("int_alu: SW must hold the latched overflow bit");
   end

   alu_op_e       op;
   logic [W-1:0]  x, y, as_r, lg_r, raw, sat_r, ds_r;
   logic          sub, ci, as_c, as_v, lg_c;
   logic          is_arith, is_abs, is_dstep, abs_pos, v_raw, c_raw;
   flag_cls_e     cls;

   assign op = alu_op_e'(op_code);

   always_comb begin
      x        = opnd_a;
      y        = opnd_b;
      sub      = 1'b0;
      ci       = 1'b0;
      is_arith = 1'b1;
      is_abs   = 1'b0;
      is_dstep = 1'b0;
      case (op)
         OP_ADD:  ;
         OP_ADDC: ci = st_in[ST_C];
         OP_SUB:  sub = 1'b1;
         OP_SUBB: begin sub = 1'b1; ci = st_in[ST_C]; end
         OP_RSUB: begin x = opnd_b; y = opnd_a; sub = 1'b1; end
         OP_NEG:  begin x = '0; sub = 1'b1; end
         OP_NEGB: begin x = '0; sub = 1'b1; ci = st_in[ST_C]; end
         OP_ABS:  begin x = '0; sub = 1'b1; is_abs = 1'b1; end
         OP_DSTEP: begin sub = 1'b1; is_arith = 1'b0; is_dstep = 1'b1; end
         default: is_arith = 1'b0;
      endcase
   end

   int_alu_addsub #(.W(W)) u_addsub (
      .x(x), .y(y), .sub(sub), .cin(ci), .r(as_r), .cout(as_c), .ovf(as_v)
   );

   int_alu_logic #(.W(W)) u_logic (
      .op(op), .a(opnd_a), .b(opnd_b), .cin(st_in[ST_C]), .r(lg_r), .cout(lg_c)
   );

   always_comb begin
      abs_pos = is_abs & ~opnd_b[W-1];
      raw     = abs_pos ? opnd_b : as_r;
      v_raw   = is_arith & ~abs_pos & as_v;
      c_raw   = is_abs ? 1'b0 : as_c;
      ds_r    = as_r[W-1] ? {opnd_a[W-2:0], 1'b0} : {as_r[W-2:0], 1'b1};
   end

   if (HAS_SAT) begin : g_sat
      assign sat_r = (sat_mode && v_raw) ? (x[W-1] ? MIN_NEG : MAX_POS) : raw;
   end else begin : g_nosat
      logic unused_sat;
      assign unused_sat = sat_mode;
      assign sat_r      = raw;
   end

   always_comb begin
      if (is_arith)      res = sat_r;
      else if (is_dstep) res = ds_r;
      else               res = lg_r;
      if (is_arith)                          cls = FL_ARITH;
      else if (is_dstep)                     cls = FL_KEEP;
      else if (op == OP_ROLC || op == OP_RORC) cls = FL_ROT;
      else                                   cls = FL_LOGIC;
   end

   int_alu_status #(.W(W), .SW(SW)) u_status (
      .clk(clk), .rst_n(rst_n), .en(upd_en), .cls(cls),
      .c_new(is_arith ? c_raw : lg_c), .v_new(v_raw), .res(res),
      .st_in(st_in), .st_q(st_q)
   );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
   parameter int W  = 32,
   parameter int SW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          upd_en,
   input logic [3:0]    op_code,
   input logic          sat_mode,
   input logic [SW-1:0] st_in,
   input logic [W-1:0]  res,
   input logic [SW-1:0] st_q
);
   import int_alu_pkg::*;

   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   // R5
   lv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && st_in[ST_LV] |=> st_q[ST_LV]);

   // R5
   ovf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && op_code <= 4'd7 |=> (!st_q[ST_V] || st_q[ST_LV]));

   // R9
   dstep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && op_code == 4'd15 |=> st_q == $past(st_in));

   // R7
   logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && op_code >= 4'd8 && op_code <= 4'd12 |=> !st_q[ST_C] && !st_q[ST_V]);

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(st_q));

   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && op_code != 4'd15 |=> st_q[ST_Z] == ($past(res) == '0));

   // R4
   sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && sat_mode && op_code <= 4'd7 |=>
         (!st_q[ST_V] || $past(res) == MAX_POS || $past(res) == MIN_NEG));
endmodule

bind int_alu int_alu_chk #(.W(W), .SW(SW)) u_int_alu_chk (
   .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_code(op_code),
   .sat_mode(sat_mode), .st_in(st_in), .res(res), .st_q(st_q)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0;
   logic [3:0]  op_code = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        sat_mode = 1'b0;
   logic [7:0]  st_in = '0;
   logic [31:0] res;
   logic [7:0]  st_q;

   int tests = 0;
   int fails = 0;
   logic [7:0] exp_st = '0;

   always #4 clk = ~clk;

   int_alu u_int_alu (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_mode(sat_mode),
      .st_in(st_in), .res(res), .st_q(st_q)
   );

   // Returns {status, result} as the requirements define them.
   function automatic logic [39:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic sat,
                                          input logic [7:0] st);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint ua = longint'({32'd0, a});
      longint ub = longint'({32'd0, b});
      longint c  = longint'(st[0]);
      longint ideal = 0;
      logic [31:0] first = a;
      logic [31:0] r = '0;
      logic [31:0] d;
      logic cf = 1'b0, vf = 1'b0;
      logic [7:0] ns = st;
      if (op <= 4'd7) begin
         case (op)
            4'd0: begin ideal = sa + sb;     cf = (ua + ub) > 64'hFFFFFFFF; end
            4'd1: begin ideal = sa + sb + c; cf = (ua + ub + c) > 64'hFFFFFFFF; end
            4'd2: begin ideal = sa - sb;     cf = ub > ua; end
            4'd3: begin ideal = sa - sb - c; cf = (ub + c) > ua; end
            4'd4: begin ideal = sb - sa;     cf = ua > ub; first = b; end
            4'd5: begin ideal = -sb;         cf = ub > 0; first = '0; end
            4'd6: begin ideal = -sb - c;     cf = (ub + c) > 0; first = '0; end
            default: begin ideal = (sb < 0) ? -sb : sb; cf = 1'b0; first = '0; end
         endcase
         r  = ideal[31:0];
         vf = (ideal > 64'sd2147483647) || (ideal < -64'sd2147483648);
         if (sat && vf) r = first[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
         ns[0] = cf; ns[1] = vf; ns[5] = st[5] | vf;
      end else if (op == 4'd15) begin
         d = a - b;
         r = d[31] ? {a[30:0], 1'b0} : {d[30:0], 1'b1};
      end else begin
         case (op)
            4'd8:  r = a & b;
            4'd9:  r = a & ~b;
            4'd10: r = a | b;
            4'd11: r = a ^ b;
            4'd12: r = ~b;
            4'd13: begin r = {a[30:0], st[0]}; cf = a[31]; end
            default: begin r = {st[0], a[31:1]}; cf = a[0]; end
         endcase
         ns[0] = cf; ns[1] = 1'b0;
      end
      if (op != 4'd15) begin
         ns[2] = (r == 0);
         ns[3] = r[31];
      end
      return {ns, r};
   endfunction

   function automatic string req_of(input logic [3:0] op);
      if (op <= 4'd1)       return "R1";
      else if (op <= 4'd6)  return "R2";
      else if (op == 4'd7)  return "R6";
      else if (op <= 4'd12) return "R7";
      else if (op <= 4'd14) return "R8";
      return "R9";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic sat, input logic [7:0] st, input logic en,
                        input string tag);
      logic [39:0] m;
      string t;
      t = (tag == "") ? req_of(op) : tag;
      m = model(op, a, b, sat, st);
      @(negedge clk);
      op_code = op; opnd_a = a; opnd_b = b; sat_mode = sat; st_in = st; upd_en = en;
      #1;
      check({t, " result"}, res, m[31:0]);
      if (en) exp_st = m[39:32];
      @(posedge clk);
      #1;
      check({t, " status"}, {24'd0, st_q}, {24'd0, exp_st});
   endtask

   function automatic logic [31:0] pick();
      logic [31:0] k;
      k = $urandom;
      if (k[0]) begin
         case (k[3:1] % 5)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            default: return 32'hFFFF_FFFF;
         endcase
      end
      return $urandom;
   endfunction

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (2) @(posedge clk);
      #1;
      // R12 reset state
      check("R12 reset", {24'd0, st_q}, 32'd0);
      rst_n = 1'b1;

      // R1 add with carry in and carry out
      do_op(4'd1, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'h01, 1'b1, "R1");
      // R3 overflow of add, wrapped
      do_op(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b0, 8'h00, 1'b1, "R3");
      // R4 clamp of add, positive side
      do_op(4'd0, 32'h7FFF_FFFF, 32'h1, 1'b1, 8'h00, 1'b1, "R4");
      // R4 clamp of reverse subtract follows b's sign
      do_op(4'd4, 32'h0000_0001, 32'h8000_0000, 1'b1, 8'h00, 1'b1, "R4");
      // R3 add with carry crossing the boundary only through C
      do_op(4'd1, 32'h7FFF_FFFF, 32'h0, 1'b1, 8'h01, 1'b1, "R3");
      // R2 borrow on subtract with borrow
      do_op(4'd3, 32'h5, 32'h5, 1'b0, 8'h01, 1'b1, "R2");
      // R2 negate with borrow of zero
      do_op(4'd6, 32'h0, 32'h0, 1'b0, 8'h01, 1'b1, "R2");
      // R6 absolute value of the most negative number, clamped
      do_op(4'd7, 32'h0, 32'h8000_0000, 1'b1, 8'h01, 1'b1, "R6");
      // R5 latched bit kept through a logic op
      do_op(4'd8, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1'b0, 8'h23, 1'b1, "R5");
      // R8 rotate through carry, both directions
      do_op(4'd13, 32'h8000_0001, 32'h0, 1'b0, 8'h00, 1'b1, "R8");
      do_op(4'd14, 32'h0000_0002, 32'h0, 1'b0, 8'h01, 1'b1, "R8");
      // R9 divide step, both branches
      do_op(4'd15, 32'h0000_0009, 32'h0000_0004, 1'b0, 8'hA5, 1'b1, "R9");
      do_op(4'd15, 32'h0000_0003, 32'h0000_0004, 1'b0, 8'h5A, 1'b1, "R9");
      // R10 zero from a clamp-free subtract
      do_op(4'd2, 32'h1234_5678, 32'h1234_5678, 1'b0, 8'h00, 1'b1, "R10");
      // R11 underflow and upper bits pass through
      do_op(4'd11, 32'h1, 32'h1, 1'b0, 8'hD0, 1'b1, "R11");
      // R12 hold when update disabled
      do_op(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 8'h00, 1'b0, "R12");

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] ra, rb, ctl;
         ra  = pick();
         rb  = pick();
         ctl = $urandom;
         do_op(ctl[3:0], ra, rb, ctl[4], ctl[15:8], ctl[18:16] != 3'd0, "");
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule